// File: doc/BRIEF.md
# Multi-format audio serial transmitter

This block sends one signed left sample and one signed right sample per frame, one bit at a time, on a single data line. The bit clock and word clock come from outside, and the block follows them as a slave. Its own logic runs on the bit clock. It watches the word clock for edges, keeps a count of where it is in the frame, and predicts the next bit slot. Data changes on the falling bit-clock edge, so a receiver can sample it on the rising edge.

A two-bit format input picks one of four framings:

- I2S.
- Left-justified.
- Right-justified.
- A DSP-style framing with a one-bit frame-sync pulse.

Each framing places the most significant bit at a different offset and ties the channels to the word clock in its own way. A two-bit width input picks 16, 20 or 24 bits per sample. Samples arrive through a valid/ready handshake that takes place once per frame. If no sample is offered, the previous pair is sent again and a sticky underrun flag is raised.

Top module: `aud_serial_tx`

## Requirements
- R1: While reset is held low at a rising bit-clock edge, the data output, the ready output and the underrun flag are all low.
- R2: With format code 0 (I2S), the word clock being low marks the left channel and high marks the right channel. The most significant bit is sent in the second bit period after each word-clock transition.
- R3: With format code 1 (left-justified), word clock high marks the left channel and low marks the right channel. The most significant bit is sent in the first bit period after the transition.
- R4: With format code 2 (right-justified), the channel polarity is the same as in R3. The least significant bit is sent in the last of the 32 bit periods of each half-frame, so the word starts at slot 32 minus the width.
- R5: With format code 3 (DSP), a word clock that is high for one bit period marks the frame. The left word starts in the next period, and the right word follows the left least significant bit with no gap. A falling word-clock edge has no effect.
- R6: Width code 0 sends 16 bits, code 1 sends 20 bits, and codes 2 and 3 send 24 bits. Samples are 24 bits wide and aligned to the top, so the top width bits are the ones sent, sign bit first.
- R7: Every bit slot outside the data word is driven low.
- R8: Ready is high for exactly one bit period, the one just before the first slot of a frame. A sample pair offered with valid during that period is the pair sent in that frame.
- R9: If valid is low while ready is high, the previous pair is sent again and the underrun flag goes high. The flag stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | External bit clock; the rising edge samples inputs, the falling edge drives data |
| rst_n | input | 1 | Synchronous active-low reset |
| word_clk | input | 1 | External word clock, or frame sync in DSP format |
| fmt_sel | input | 2 | Framing format: 0 I2S, 1 left-justified, 2 right-justified, 3 DSP |
| width_sel | input | 2 | Word width: 0 for 16, 1 for 20, 2 or 3 for 24 |
| smp_valid | input | 1 | A sample pair is offered |
| smp_ready | output | 1 | The block takes a pair at this rising edge |
| smp_left | input | 24 | Left sample, two's complement, top-aligned |
| smp_right | input | 24 | Right sample, two's complement, top-aligned |
| ser_data | output | 1 | Serial data output |
| underrun | output | 1 | Sticky flag: a frame started with no fresh sample |

## Verification
The hardest situation to reach is an underrun. Valid must be low in the single bit period where ready is high, and a pair must be offered again before the next boundary. Only then can the resent frame be told apart from a new one. The bench withholds valid for exactly one frame, then checks that the following frame repeats the old pair and that the flag stays set. The sweep runs every format at every width code over whole frames, so the short right-justified words and the gapless DSP right word are both covered bit by bit.

// File: rtl/aud_tx_pkg.sv
// Shared types and helpers for the audio serial transmitter.
// Assumes widths returned here never exceed the 24-bit sample input.
package aud_tx_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_DSP = 2'd3
    } fmt_e;

    // Map the width select code to a word length in bits.
    function automatic int width_of(logic [1:0] sel);
        case (sel)
            2'd0:    return 16;
            2'd1:    return 20;
            default: return 24;
        endcase
    endfunction

endpackage

// File: rtl/aud_frame_tracker.sv
// Follows the external word clock and keeps the frame slot counter.
// pos_q holds the slot index of the bit period that the next falling edge
// starts. Bit POS_W-1 selects the half (0 for left), and the low bits give
// the slot within that half. Assumes HALF_LEN is a power of two, and that
// the word clock changes on falling bit-clock edges.
module aud_frame_tracker #(
    parameter int HALF_LEN = 32,
    localparam int HALF_W  = $clog2(HALF_LEN),
    localparam int POS_W   = HALF_W + 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  word_clk,
    input  aud_tx_pkg::fmt_e      fmt,
    output logic [POS_W-1:0]      pos_q,
    output logic                  locked,
    output logic                  frame_start
);
    import aud_tx_pkg::*;

    logic             wclk_q;
    logic             wc_rise;
    logic             wc_fall;
    logic             sync_hit;
    logic [POS_W-1:0] pos_d;

    assign wc_rise = word_clk & ~wclk_q;
    assign wc_fall = ~word_clk & wclk_q;

    // Next slot index: resynchronise on a meaningful edge, else count on.
    always_comb begin
        pos_d    = pos_q + 1'b1;
        sync_hit = 1'b0;
        case (fmt)
            FMT_DSP: begin
                if (wc_rise) begin
                    pos_d    = '0;
                    sync_hit = 1'b1;
                end
            end
            FMT_I2S: begin
                if (wc_rise || wc_fall) begin
                    pos_d    = {wc_rise, HALF_W'(1)};
                    sync_hit = 1'b1;
                end
            end
            default: begin
                if (wc_rise || wc_fall) begin
                    pos_d    = {wc_fall, HALF_W'(1)};
                    sync_hit = 1'b1;
                end
            end
        endcase
    end

    assign frame_start = locked && (pos_d == '0);

    // Register the word clock, the slot counter and the lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wclk_q <= 1'b0;
            pos_q  <= '0;
            locked <= 1'b0;
        end else begin
            wclk_q <= word_clk;
            pos_q  <= pos_d;
            if (sync_hit) locked <= 1'b1;
        end
    end

endmodule

// File: rtl/aud_sample_hold.sv
// Holds the sample pair for the frame being sent. It accepts a new pair at
// each frame boundary through the valid/ready handshake. When no pair is
// offered, it keeps the old one and sets a sticky underrun flag.
module aud_sample_hold #(
    parameter int SAMPLE_W = 24
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frame_start,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                smp_ready,
    output logic [SAMPLE_W-1:0] held_left,
    output logic [SAMPLE_W-1:0] held_right,
    output logic                underrun
);
    assign smp_ready = frame_start;

    // Take a pair at the boundary, or flag the missing one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_left  <= '0;
            held_right <= '0;
            underrun   <= 1'b0;
        end else if (frame_start) begin
            if (smp_valid) begin
                held_left  <= smp_left;
                held_right <= smp_right;
            end else begin
                underrun <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/aud_slot_mapper.sv
// Combinational map from slot index, format and width to the output bit.
// A format picks the word offset and the channel for the slot. Slots that
// fall outside the word give zero. Samples are top-aligned.
module aud_slot_mapper #(
    parameter int SAMPLE_W = 24,
    parameter int HALF_LEN = 32,
    localparam int HALF_W  = $clog2(HALF_LEN),
    localparam int POS_W   = HALF_W + 1
) (
    input  aud_tx_pkg::fmt_e     fmt,
    input  logic [1:0]           width_sel,
    input  logic [POS_W-1:0]     pos,
    input  logic [SAMPLE_W-1:0]  left,
    input  logic [SAMPLE_W-1:0]  right,
    output logic                 slot_bit
);
    import aud_tx_pkg::*;

    int                  wlen;
    int                  in_half;
    int                  in_frame;
    int                  bit_no;
    logic                pick_right;
    logic [SAMPLE_W-1:0] chan;
    logic [SAMPLE_W-1:0] shifted;

    // Work out which bit of which word the slot carries.
    always_comb begin
        wlen       = width_of(width_sel);
        in_half    = int'(pos[HALF_W-1:0]);
        in_frame   = int'(pos);
        pick_right = pos[POS_W-1];
        case (fmt)
            FMT_I2S: bit_no = in_half - 1;
            FMT_LJ:  bit_no = in_half;
            FMT_RJ:  bit_no = in_half - (HALF_LEN - wlen);
            default: begin
                if (in_frame < wlen) begin
                    bit_no     = in_frame;
                    pick_right = 1'b0;
                end else begin
                    bit_no     = in_frame - wlen;
                    pick_right = 1'b1;
                end
            end
        endcase
        chan     = pick_right ? right : left;
        shifted  = '0;
        slot_bit = 1'b0;
        if (bit_no >= 0 && bit_no < wlen) begin
            shifted  = chan << bit_no;
            slot_bit = shifted[SAMPLE_W-1];
        end
    end

endmodule

// File: rtl/aud_serial_tx.sv
// Multi-format audio serial transmitter, slave to external clocks.
// Inputs are sampled on rising bit-clock edges. The data line is driven
// from a falling-edge register. The output stays low until the first
// word-clock edge that is valid for the selected format has been seen.
module aud_serial_tx #(
    parameter int SAMPLE_W = 24,
    parameter int HALF_LEN = 32,
    localparam int HALF_W  = $clog2(HALF_LEN),
    localparam int POS_W   = HALF_W + 1
) (
    input  logic                bit_clk,
    input  logic                rst_n,
    input  logic                word_clk,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          width_sel,
    input  logic                smp_valid,
    output logic                smp_ready,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                ser_data,
    output logic                underrun
);
    aud_tx_pkg::fmt_e    fmt;
    logic [POS_W-1:0]    pos_q;
    logic                locked;
    logic                frame_start;
    logic [SAMPLE_W-1:0] held_left;
    logic [SAMPLE_W-1:0] held_right;
    logic                slot_bit;
    logic                ser_data_q;

    assign fmt = aud_tx_pkg::fmt_e'(fmt_sel);

    aud_frame_tracker #(.HALF_LEN(HALF_LEN)) i_tracker (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .word_clk    (word_clk),
        .fmt         (fmt),
        .pos_q       (pos_q),
        .locked      (locked),
        .frame_start (frame_start)
    );

    aud_sample_hold #(.SAMPLE_W(SAMPLE_W)) i_hold (
        .clk         (bit_clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .smp_valid   (smp_valid),
        .smp_left    (smp_left),
        .smp_right   (smp_right),
        .smp_ready   (smp_ready),
        .held_left   (held_left),
        .held_right  (held_right),
        .underrun    (underrun)
    );

    aud_slot_mapper #(.SAMPLE_W(SAMPLE_W), .HALF_LEN(HALF_LEN)) i_mapper (
        .fmt       (fmt),
        .width_sel (width_sel),
        .pos       (pos_q),
        .left      (held_left),
        .right     (held_right),
        .slot_bit  (slot_bit)
    );

    // Launch the slot bit on the falling edge; keep it quiet until locked.
    always_ff @(negedge bit_clk) begin
        if (!rst_n) ser_data_q <= 1'b0;
        else        ser_data_q <= locked && slot_bit;
    end

    assign ser_data = ser_data_q;

endmodule

// File: rtl/aud_tx_checker.sv
// Property checker for aud_serial_tx, attached with bind.
// It relies on the top's internal slot counter and lock flag.
module aud_tx_checker #(
    parameter int HALF_LEN = 32,
    localparam int HALF_W  = $clog2(HALF_LEN),
    localparam int POS_W   = HALF_W + 1
) (
    input logic             bit_clk,
    input logic             rst_n,
    input logic [1:0]       fmt_sel,
    input logic [1:0]       width_sel,
    input logic             smp_valid,
    input logic             smp_ready,
    input logic             underrun,
    input logic             ser_data,
    input logic             locked,
    input logic [POS_W-1:0] pos_q
);
    AST_RESET_QUIET: assert property (@(posedge bit_clk)
        !rst_n |=> (!underrun && !smp_ready && !ser_data)); // R1

    AST_UNDERRUN_STICKY: assert property (@(posedge bit_clk) disable iff (!rst_n)
        underrun |=> underrun); // R9

    AST_UNDERRUN_ON_MISS: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (smp_ready && !smp_valid) |=> underrun); // R9

    AST_READY_SINGLE: assert property (@(posedge bit_clk) disable iff (!rst_n)
        smp_ready |=> !smp_ready); // R8

    AST_READY_AT_SLOT_ZERO: assert property (@(posedge bit_clk) disable iff (!rst_n)
        smp_ready |=> (pos_q == '0)); // R8

    AST_LJ_PAD_LOW: assert property (@(posedge bit_clk) disable iff (!rst_n)
        (locked && fmt_sel == 2'd1 &&
         int'(pos_q[HALF_W-1:0]) >= aud_tx_pkg::width_of(width_sel)) |-> !ser_data); // R7

endmodule

bind aud_serial_tx aud_tx_checker #(.HALF_LEN(HALF_LEN)) i_aud_tx_checker (
    .bit_clk   (bit_clk),
    .rst_n     (rst_n),
    .fmt_sel   (fmt_sel),
    .width_sel (width_sel),
    .smp_valid (smp_valid),
    .smp_ready (smp_ready),
    .underrun  (underrun),
    .ser_data  (ser_data),
    .locked    (locked),
    .pos_q     (pos_q)
);

// File: tb/test_aud_serial_tx.sv
// Sweeps every format and width code over whole frames. The bench builds
// the word clock and predicts each output bit from the framing rules.
module test_aud_serial_tx;

    logic        clk = 1'b1;
    logic        rst_n = 1'b0;
    logic        word_clk = 1'b0;
    logic [1:0]  fmt_sel = 2'd0;
    logic [1:0]  width_sel = 2'd0;
    logic        smp_valid = 1'b1;
    logic        smp_ready;
    logic [23:0] smp_left = '0;
    logic [23:0] smp_right = '0;
    logic        ser_data;
    logic        underrun;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    aud_serial_tx i_aud_serial_tx (
        .bit_clk   (clk),
        .rst_n     (rst_n),
        .word_clk  (word_clk),
        .fmt_sel   (fmt_sel),
        .width_sel (width_sel),
        .smp_valid (smp_valid),
        .smp_ready (smp_ready),
        .smp_left  (smp_left),
        .smp_right (smp_right),
        .ser_data  (ser_data),
        .underrun  (underrun)
    );

    task automatic check(string req, logic [23:0] act, logic [23:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [23:0] pat_l(int cfg, int f);
        return 24'hC35A96 + 24'(f) * 24'h01F3E7 + 24'(cfg) * 24'h010101;
    endfunction

    function automatic logic [23:0] pat_r(int cfg, int f);
        return 24'h3CA569 - 24'(f) * 24'h00B1D3 + 24'(cfg) * 24'h0F0F01;
    endfunction

    function automatic int wlen_of(int ws);
        return (ws == 0) ? 16 : (ws == 1) ? 20 : 24;
    endfunction

    // Word clock level the bench drives in period t of a 64-period frame.
    function automatic logic wclk_for(int mode, int t);
        case (mode)
            0:       return (t >= 32);
            3:       return (t == 63);
            default: return (t < 32);
        endcase
    endfunction

    // Expected bit in period t, straight from R2..R7.
    function automatic logic exp_bit(int mode, int w, int t, logic [23:0] l, logic [23:0] r);
        int          k;
        logic [23:0] s;
        s = (t >= 32) ? r : l;
        case (mode)
            0: k = (t % 32) - 1;
            1: k = t % 32;
            2: k = (t % 32) - (32 - w);
            default: begin
                if (t < w) begin k = t; s = l; end
                else begin k = t - w; s = r; end
            end
        endcase
        if (k < 0 || k >= w) return 1'b0;
        return s[23 - k];
    endfunction

    task automatic do_reset(int mode, int ws);
        rst_n     = 1'b0;
        word_clk  = 1'b0;
        smp_valid = 1'b1;
        fmt_sel   = 2'(mode);
        width_sel = 2'(ws);
        repeat (3) @(posedge clk);
        #1;
        check("R1 ser_data", 24'(ser_data), 24'd0);
        check("R1 smp_ready", 24'(smp_ready), 24'd0);
        check("R1 underrun", 24'(underrun), 24'd0);
        @(negedge clk);
        #1 rst_n = 1'b1;
    endtask

    // Run nf frames; drop_f >= 0 withholds valid during that frame.
    task automatic run_cfg(int mode, int ws, int nf, int drop_f);
        int          cfg;
        int          w;
        logic [23:0] el;
        logic [23:0] er;
        logic        want_ur;
        cfg = mode * 4 + ws;
        w   = wlen_of(ws);
        smp_left  = pat_l(cfg, 0);
        smp_right = pat_r(cfg, 0);
        do_reset(mode, ws);
        for (int f = 0; f < nf; f++) begin
            if (f == drop_f + 1 && drop_f >= 0) begin
                el = pat_l(cfg, drop_f);
                er = pat_r(cfg, drop_f);
            end else begin
                el = pat_l(cfg, f);
                er = pat_r(cfg, f);
            end
            want_ur = (drop_f >= 0 && f >= drop_f);
            for (int t = 0; t < 64; t++) begin
                @(negedge clk);
                word_clk = wclk_for(mode, t);
                if (t == 0) begin
                    smp_left  = pat_l(cfg, f + 1);
                    smp_right = pat_r(cfg, f + 1);
                    smp_valid = (f != drop_f);
                end
                #1;
                if (f >= 1 && t == 63) check("R8 ready at boundary", 24'(smp_ready), 24'd1);
                if (f >= 1 && t == 10) check("R8 ready mid-frame", 24'(smp_ready), 24'd0);
                @(posedge clk);
                #1;
                if (f >= 2) begin
                    case (mode)
                        0:       check("R2 R6 R7 i2s bit", 24'(ser_data), 24'(exp_bit(mode, w, t, el, er)));
                        1:       check("R3 R6 R7 lj bit", 24'(ser_data), 24'(exp_bit(mode, w, t, el, er)));
                        2:       check("R4 R6 R7 rj bit", 24'(ser_data), 24'(exp_bit(mode, w, t, el, er)));
                        default: check("R5 R6 R7 dsp bit", 24'(ser_data), 24'(exp_bit(mode, w, t, el, er)));
                    endcase
                end
                if (t == 63) check("R9 underrun flag", 24'(underrun), 24'(want_ur));
            end
        end
    endtask

    initial begin
        for (int m = 0; m < 4; m++)
            for (int ws = 0; ws < 4; ws++)
                run_cfg(m, ws, 4, -1);
        run_cfg(1, 2, 6, 2);  // R9: one missed handshake in left-justified
        run_cfg(2, 0, 6, 3);  // R9: one missed handshake in right-justified
        run_cfg(1, 2, 3, -1); // R1: reset clears the sticky flag
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule